// File: doc/BRIEF.md
# Fully Associative Victim Line Store

This block holds a handful of cache lines that a 2-way, 16 KB first-level data cache has just thrown out. The first-level cache has 32-byte lines and 256 sets. Whenever the first-level cache replaces a line during a refill, it passes the outgoing line here, together with its 19-bit tag, its 8-bit set number, its data and a dirty flag. Because the store has no set index, it names each line by the 27-bit value {tag, set} and compares every slot on each search.

A search is issued only after the first-level cache has found a miss. The answer arrives on the following clock edge, so a hit in this store costs the requester one cycle beyond the first-level miss. A hit hands the line back, including its dirty flag, and frees the slot. If the first-level cache pushes a new victim in the same cycle, that victim takes over the slot being handed back. This swap needs no write-back. A miss leaves the store unchanged, because the refill from the next level goes into the first-level cache only.

New victims fill free slots first. When every slot is full, a new victim replaces the least recently inserted line. If the replaced line is dirty, it is sent to the next level as a one-cycle write-back. A flush request writes back every dirty line, one per cycle, and then empties the store.

Top module: `victim_cache`

## Requirements
- R1: After reset no response and no write-back is presented, `flush_busy_o` is 0, and every search misses.
- R2: A search presented with `lookup_valid_i` in cycle t produces `resp_valid_o` high for exactly the cycle after edge t, with `resp_hit_o` giving the result.
- R3: A hit needs equality of the full 27-bit key {19-bit tag, 8-bit set}. A stored line with the same tag but a different set number does not match.
- R4: A hit returns the stored 256-bit line and its dirty flag on `resp_data_o` / `resp_dirty_o`, and removes the line, so the same search made later misses.
- R5: When all `ENTRIES` slots are valid, an inserted line replaces the line whose most recent insertion is the oldest.
- R6: Replacing a dirty line pulses `wb_valid_o` for one cycle after the insert edge, with `wb_line_o` = {tag, set} and `wb_data_o` = that line's data. Replacing a clean line, or filling a free slot, causes no write-back.
- R7: A search that misses allocates nothing and changes neither the contents nor the replacement order.
- R8: A hit and an insert in the same cycle swap. The new line takes the slot being handed back, it becomes the most recently inserted line, and no write-back happens, even when the store is full.
- R9: A one-cycle `flush_i` raises `flush_busy_o` from the next edge. The store then writes back each dirty line exactly once, one per cycle, and `flush_busy_o` stays high for (number of dirty lines + 1) cycles. Afterwards every search misses.
- R10: In the cycle `flush_i` is high and while `flush_busy_o` is high, searches answer with a miss and inserts are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lookup_valid_i | input | 1 | Search request after a first-level miss |
| lookup_tag_i | input | 19 | First-level tag of the searched line |
| lookup_set_i | input | 8 | First-level set number of the searched line |
| insert_valid_i | input | 1 | A line evicted from the first-level cache is offered |
| insert_tag_i | input | 19 | First-level tag of the evicted line |
| insert_set_i | input | 8 | First-level set number of the evicted line |
| insert_data_i | input | 256 | Evicted line data |
| insert_dirty_i | input | 1 | Evicted line is modified |
| flush_i | input | 1 | Start writing back and emptying the store |
| resp_valid_o | output | 1 | Search result valid |
| resp_hit_o | output | 1 | Search found the line |
| resp_data_o | output | 256 | Returned line data on a hit |
| resp_dirty_o | output | 1 | Returned line was modified |
| wb_valid_o | output | 1 | Write-back to next level valid |
| wb_line_o | output | 27 | Line address {tag, set} of the write-back |
| wb_data_o | output | 256 | Write-back data |
| flush_busy_o | output | 1 | Flush in progress |

## Verification
The interesting collision is a search that hits while a new victim arrives in the same cycle, with every slot already full. The bench fills the store, then drives a hit search and a dirty insert on one edge. It judges the swap by three observations. The response carries the old line, no write-back appears, and the next insert evicts the line that was oldest before the swap rather than the one just swapped in. A second overlap is a search and an insert issued during the first busy cycle of a flush. The bench expects a miss there and checks later that the insert never landed.

// File: rtl/vc_pkg.sv
package vc_pkg;
    typedef enum logic {
        MODE_RUN   = 1'b0,
        MODE_FLUSH = 1'b1
    } vc_mode_e;
endpackage

// File: rtl/vc_pick.sv
// Lowest-index selector over a request vector.
module vc_pick #(
    parameter int ENTRIES = 4
) (
    input  logic [ENTRIES-1:0]         req_i,
    output logic                       any_o,
    output logic [$clog2(ENTRIES)-1:0] idx_o
);
    localparam int AW = $clog2(ENTRIES);

    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = AW'(i);
        end
    end
endmodule

// File: rtl/vc_match.sv
// Parallel key compare across every slot.
module vc_match #(
    parameter int ENTRIES = 4,
    parameter int KEY_W   = 27
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][KEY_W-1:0] keys_i,
    input  logic [KEY_W-1:0]              probe_i,
    output logic [ENTRIES-1:0]            hit_vec_o,
    output logic                          hit_o,
    output logic [$clog2(ENTRIES)-1:0]    hit_idx_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec_o[g] = valid_i[g] && (keys_i[g] == probe_i);
    end

    vc_pick #(.ENTRIES(ENTRIES)) u_pick (
        .req_i (hit_vec_o),
        .any_o (hit_o),
        .idx_o (hit_idx_o)
    );
endmodule

// File: rtl/vc_age.sv
// Per-slot age counters; age 0 is newest, ENTRIES-1 is the replacement candidate.
module vc_age #(
    parameter int ENTRIES = 4
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       touch_i,
    input  logic [$clog2(ENTRIES)-1:0] touch_idx_i,
    output logic [$clog2(ENTRIES)-1:0] lru_idx_o
);
    localparam int AW = $clog2(ENTRIES);

    typedef logic [ENTRIES-1:0][AW-1:0] age_t;
    age_t age_d, age_q;
    logic [ENTRIES-1:0] oldest_vec;
    logic               oldest_any;

    always_comb begin
        age_d = age_q;
        if (touch_i) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (age_q[j] < age_q[touch_idx_i]) age_d[j] = age_q[j] + 1'b1;
            end
            age_d[touch_idx_i] = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= AW'(i);
        end else begin
            age_q <= age_d;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
        assign oldest_vec[g] = (age_q[g] == AW'(ENTRIES - 1));
    end

    vc_pick #(.ENTRIES(ENTRIES)) u_pick (
        .req_i (oldest_vec),
        .any_o (oldest_any),
        .idx_o (lru_idx_o)
    );

    // R5
    lru_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(oldest_vec) == 1);

    // R5
    touch_newest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        touch_i |=> age_q[$past(touch_idx_i)] == '0);
endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
    parameter int ENTRIES    = 4,
    parameter int TAG_W      = 19,
    parameter int SET_W      = 8,
    parameter int LINE_BYTES = 32
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   lookup_valid_i,
    input  logic [TAG_W-1:0]       lookup_tag_i,
    input  logic [SET_W-1:0]       lookup_set_i,
    input  logic                   insert_valid_i,
    input  logic [TAG_W-1:0]       insert_tag_i,
    input  logic [SET_W-1:0]       insert_set_i,
    input  logic [LINE_BYTES*8-1:0] insert_data_i,
    input  logic                   insert_dirty_i,
    input  logic                   flush_i,
    output logic                   resp_valid_o,
    output logic                   resp_hit_o,
    output logic [LINE_BYTES*8-1:0] resp_data_o,
    output logic                   resp_dirty_o,
    output logic                   wb_valid_o,
    output logic [TAG_W+SET_W-1:0] wb_line_o,
    output logic [LINE_BYTES*8-1:0] wb_data_o,
    output logic                   flush_busy_o
);
    import vc_pkg::*;

    localparam int KEY_W  = TAG_W + SET_W;
    localparam int DATA_W = LINE_BYTES * 8;
    localparam int EW     = $clog2(ENTRIES);

    typedef struct packed {
        vc_mode_e                         mode;
        logic [ENTRIES-1:0]               valid;
        logic [ENTRIES-1:0]               dirty;
        logic [ENTRIES-1:0][KEY_W-1:0]    key;
        logic [ENTRIES-1:0][DATA_W-1:0]   data;
        logic                             resp_valid;
        logic                             resp_hit;
        logic                             resp_dirty;
        logic [DATA_W-1:0]                resp_data;
        logic                             wb_valid;
        logic [KEY_W-1:0]                 wb_line;
        logic [DATA_W-1:0]                wb_data;
    } vc_state_t;

    vc_state_t st_d, st_q;

    logic [KEY_W-1:0]   probe_key, ins_key;
    logic [ENTRIES-1:0] hit_vec;
    logic               hit_any;
    logic [EW-1:0]      hit_idx;
    logic               free_any, dirty_any;
    logic [EW-1:0]      free_idx, dirty_idx, lru_idx;
    logic               touch;
    logic [EW-1:0]      touch_idx;
    logic               blocked;
    logic               swap;
    logic [EW-1:0]      slot;

    assign probe_key = {lookup_tag_i, lookup_set_i};
    assign ins_key   = {insert_tag_i, insert_set_i};

    vc_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_match (
        .valid_i   (st_q.valid),
        .keys_i    (st_q.key),
        .probe_i   (probe_key),
        .hit_vec_o (hit_vec),
        .hit_o     (hit_any),
        .hit_idx_o (hit_idx)
    );

    vc_pick #(.ENTRIES(ENTRIES)) u_free (
        .req_i (~st_q.valid),
        .any_o (free_any),
        .idx_o (free_idx)
    );

    vc_pick #(.ENTRIES(ENTRIES)) u_dirty (
        .req_i (st_q.valid & st_q.dirty),
        .any_o (dirty_any),
        .idx_o (dirty_idx)
    );

    vc_age #(.ENTRIES(ENTRIES)) u_age (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .touch_i     (touch),
        .touch_idx_i (touch_idx),
        .lru_idx_o   (lru_idx)
    );

    always_comb begin
        st_d            = st_q;
        st_d.resp_valid = 1'b0;
        st_d.resp_hit   = 1'b0;
        st_d.resp_dirty = 1'b0;
        st_d.resp_data  = '0;
        st_d.wb_valid   = 1'b0;
        touch           = 1'b0;
        touch_idx       = '0;
        blocked         = (st_q.mode == MODE_FLUSH) || flush_i;
        swap            = lookup_valid_i && !blocked && hit_any;
        slot            = swap ? hit_idx : (free_any ? free_idx : lru_idx);

        // flush sequencing: one dirty line per cycle, then clear everything
        if (st_q.mode == MODE_FLUSH) begin
            if (dirty_any) begin
                st_d.wb_valid         = 1'b1;
                st_d.wb_line          = st_q.key[dirty_idx];
                st_d.wb_data          = st_q.data[dirty_idx];
                st_d.valid[dirty_idx] = 1'b0;
                st_d.dirty[dirty_idx] = 1'b0;
            end else begin
                st_d.valid = '0;
                st_d.dirty = '0;
                st_d.mode  = MODE_RUN;
            end
        end else if (flush_i) begin
            st_d.mode = MODE_FLUSH;
        end

        // search: answer next cycle, hand the line back and free its slot
        if (lookup_valid_i) begin
            st_d.resp_valid = 1'b1;
            if (swap) begin
                st_d.resp_hit       = 1'b1;
                st_d.resp_data      = st_q.data[hit_idx];
                st_d.resp_dirty     = st_q.dirty[hit_idx];
                st_d.valid[hit_idx] = 1'b0;
                st_d.dirty[hit_idx] = 1'b0;
            end
        end

        // insert: swap slot, else free slot, else least recent slot
        if (insert_valid_i && !blocked) begin
            if (!swap && !free_any && st_q.dirty[slot]) begin
                st_d.wb_valid = 1'b1;
                st_d.wb_line  = st_q.key[slot];
                st_d.wb_data  = st_q.data[slot];
            end
            st_d.valid[slot] = 1'b1;
            st_d.dirty[slot] = insert_dirty_i;
            st_d.key[slot]   = ins_key;
            st_d.data[slot]  = insert_data_i;
            touch            = 1'b1;
            touch_idx        = slot;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q            <= '0;
            st_q.mode       <= MODE_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid_o = st_q.resp_valid;
    assign resp_hit_o   = st_q.resp_hit;
    assign resp_data_o  = st_q.resp_data;
    assign resp_dirty_o = st_q.resp_dirty;
    assign wb_valid_o   = st_q.wb_valid;
    assign wb_line_o    = st_q.wb_line;
    assign wb_data_o    = st_q.wb_data;
    assign flush_busy_o = (st_q.mode == MODE_FLUSH);

    // R2
    resp_next_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lookup_valid_i |=> resp_valid_o);

    // R3
    single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(hit_vec));

    // R6
    wb_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wb_valid_o |-> ($past(insert_valid_i) || $past(flush_busy_o)));

    // R9
    flush_drains_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_busy_o |=> ($countones(st_q.valid) <= $past($countones(st_q.valid))));

    // R10
    flush_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flush_busy_o || flush_i) |=> !resp_hit_o);
endmodule

// File: tb/tb_victim_cache.sv
module tb_victim_cache;
    localparam int N = 4;

    typedef struct {
        logic [26:0]  key;
        logic [255:0] data;
        bit           dirty;
    } line_t;

    typedef struct {
        bit           hit;
        logic [255:0] data;
        bit           dirty;
        string        rq;
    } resp_t;

    typedef struct {
        logic [26:0]  key;
        logic [255:0] data;
        string        rq;
    } wb_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lookup_valid = 1'b0;
    logic [18:0]  lookup_tag = '0;
    logic [7:0]   lookup_set = '0;
    logic         insert_valid = 1'b0;
    logic [18:0]  insert_tag = '0;
    logic [7:0]   insert_set = '0;
    logic [255:0] insert_data = '0;
    logic         insert_dirty = 1'b0;
    logic         flush = 1'b0;
    logic         resp_valid, resp_hit, resp_dirty, wb_valid, flush_busy;
    logic [255:0] resp_data, wb_data;
    logic [26:0]  wb_line;

    int checks = 0;
    int failures = 0;
    bit mon_on = 1'b0;
    bit m_flush = 1'b0;

    line_t model[$];
    resp_t exp_resp[$];
    wb_t   exp_wb[$];

    always #10 clk = ~clk;

    victim_cache dut (
        .clk_i(clk), .rst_ni(rst_n),
        .lookup_valid_i(lookup_valid), .lookup_tag_i(lookup_tag), .lookup_set_i(lookup_set),
        .insert_valid_i(insert_valid), .insert_tag_i(insert_tag), .insert_set_i(insert_set),
        .insert_data_i(insert_data), .insert_dirty_i(insert_dirty), .flush_i(flush),
        .resp_valid_o(resp_valid), .resp_hit_o(resp_hit), .resp_data_o(resp_data),
        .resp_dirty_o(resp_dirty), .wb_valid_o(wb_valid), .wb_line_o(wb_line),
        .wb_data_o(wb_data), .flush_busy_o(flush_busy)
    );

    function automatic logic [255:0] pat(input int n);
        return {8{32'hA5000000 + 32'(n) * 32'h01010101}};
    endfunction

    function automatic logic [26:0] k(input int t, input int s);
        return {19'(t), 8'(s)};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // monitor: compares design outputs against the scoreboard queues
    always @(negedge clk) begin
        if (mon_on) begin
            if (resp_valid) begin
                if (exp_resp.size() == 0) begin
                    chk(1'b0, "R2", "unexpected response", 256'(resp_hit), 256'd0);
                end else begin
                    resp_t e;
                    e = exp_resp.pop_front();
                    chk(resp_hit == e.hit, e.rq, "resp_hit", 256'(resp_hit), 256'(e.hit));
                    if (e.hit) begin
                        chk(resp_data == e.data, e.rq, "resp_data", resp_data, e.data);
                        chk(resp_dirty == e.dirty, e.rq, "resp_dirty", 256'(resp_dirty), 256'(e.dirty));
                    end
                end
            end
            if (wb_valid) begin
                if (m_flush) begin
                    int f;
                    f = -1;
                    foreach (exp_wb[i]) if (exp_wb[i].key == wb_line) f = i;
                    chk(f >= 0, "R9", "flush write-back line", 256'(wb_line), 256'd0);
                    if (f >= 0) begin
                        chk(wb_data == exp_wb[f].data, "R9", "flush write-back data", wb_data, exp_wb[f].data);
                        exp_wb.delete(f);
                    end
                end else if (exp_wb.size() == 0) begin
                    chk(1'b0, "R6", "unexpected write-back", 256'(wb_line), 256'd0);
                end else begin
                    wb_t w;
                    w = exp_wb.pop_front();
                    chk(wb_line == w.key, w.rq, "wb_line", 256'(wb_line), 256'(w.key));
                    chk(wb_data == w.data, w.rq, "wb_data", wb_data, w.data);
                end
            end
        end
    end

    // driver: one cycle of stimulus, model updated and expectations pushed
    task automatic step(input bit lk, input logic [26:0] lkey,
                        input bit ins, input logic [26:0] ikey, input int idn,
                        input bit idirty, input string rq);
        int    f;
        bit    swp;
        bit    blk;
        @(negedge clk);
        lookup_valid = lk;  {lookup_tag, lookup_set} = lkey;
        insert_valid = ins; {insert_tag, insert_set} = ikey;
        insert_data  = pat(idn); insert_dirty = idirty;
        blk = m_flush;
        f = -1;
        foreach (model[i]) if (model[i].key == lkey) f = i;
        swp = lk && !blk && (f >= 0);
        if (lk) begin
            resp_t r;
            r.hit = swp; r.rq = rq;
            r.data = swp ? model[f].data : '0;
            r.dirty = swp ? model[f].dirty : 1'b0;
            exp_resp.push_back(r);
            if (swp) model.delete(f);
        end
        if (ins && !blk) begin
            line_t nl;
            if (!swp && model.size() == N) begin
                line_t old;
                old = model.pop_front();
                if (old.dirty) begin
                    wb_t w;
                    w.key = old.key; w.data = old.data; w.rq = rq;
                    exp_wb.push_back(w);
                end
            end
            nl.key = ikey; nl.data = pat(idn); nl.dirty = idirty;
            model.push_back(nl);
        end
        @(posedge clk);
        @(negedge clk);
        lookup_valid = 1'b0;
        insert_valid = 1'b0;
    endtask

    task automatic drain(input string rq);
        repeat (2) @(negedge clk);
        chk(exp_resp.size() == 0, rq, "responses outstanding", 256'(exp_resp.size()), 256'd0);
        chk(exp_wb.size() == 0, rq, "write-backs outstanding", 256'(exp_wb.size()), 256'd0);
    endtask

    task automatic do_flush(input bit inject, input logic [26:0] pkey, input logic [26:0] nkey);
        int nd;
        int busy_n;
        nd = 0;
        @(negedge clk);
        flush = 1'b1;
        foreach (model[i]) if (model[i].dirty) begin
            wb_t w;
            w.key = model[i].key; w.data = model[i].data; w.rq = "R9";
            exp_wb.push_back(w);
            nd++;
        end
        model.delete();
        m_flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(flush_busy == 1'b1, "R9", "busy after flush", 256'(flush_busy), 256'd1);
        busy_n = 0;
        if (inject) begin
            // R10: search and insert during the first busy cycle
            lookup_valid = 1'b1; {lookup_tag, lookup_set} = pkey;
            insert_valid = 1'b1; {insert_tag, insert_set} = nkey;
            insert_data = pat(99); insert_dirty = 1'b1;
            begin
                resp_t r;
                r.hit = 1'b0; r.data = '0; r.dirty = 1'b0; r.rq = "R10";
                exp_resp.push_back(r);
            end
        end
        while (flush_busy && busy_n < 50) begin
            busy_n++;
            @(negedge clk);
            lookup_valid = 1'b0;
            insert_valid = 1'b0;
        end
        m_flush = 1'b0;
        chk(busy_n == nd + 1, "R9", "busy cycle count", 256'(busy_n), 256'(nd + 1));
        chk(exp_wb.size() == 0, "R9", "dirty lines not written back", 256'(exp_wb.size()), 256'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(resp_valid == 1'b0, "R1", "resp_valid after reset", 256'(resp_valid), 256'd0);
        chk(wb_valid == 1'b0, "R1", "wb_valid after reset", 256'(wb_valid), 256'd0);
        chk(flush_busy == 1'b0, "R1", "flush_busy after reset", 256'(flush_busy), 256'd0);
        mon_on = 1'b1;
        step(1, k(5, 3), 0, '0, 0, 0, "R1");

        // fill with a mix of dirty and clean lines (R6: free slots, no write-back)
        step(0, '0, 1, k(100, 1), 1, 1, "R6");
        step(0, '0, 1, k(101, 2), 2, 0, "R6");
        step(0, '0, 1, k(102, 3), 3, 1, "R6");
        step(0, '0, 1, k(103, 4), 4, 0, "R6");
        // R4: hit returns data and frees
        step(1, k(101, 2), 0, '0, 0, 0, "R4");
        step(1, k(101, 2), 0, '0, 0, 0, "R4");
        step(1, k(102, 3), 0, '0, 0, 0, "R4");
        step(0, '0, 1, k(102, 3), 3, 1, "R4");
        // R3: same tag, other set misses
        step(1, k(100, 7), 0, '0, 0, 0, "R3");
        step(1, k(7, 1), 0, '0, 0, 0, "R3");
        // R7: miss allocates nothing
        step(1, k(200, 9), 0, '0, 0, 0, "R7");
        step(1, k(200, 9), 0, '0, 0, 0, "R7");
        drain("R4");

        // R5/R6: full store replaces oldest, dirty victims written back
        step(0, '0, 1, k(104, 5), 5, 1, "R5");
        step(0, '0, 1, k(105, 6), 6, 0, "R5");
        step(0, '0, 1, k(106, 7), 7, 1, "R6");
        step(0, '0, 1, k(107, 8), 8, 0, "R6");
        step(0, '0, 1, k(108, 9), 9, 0, "R6");
        drain("R5");

        // R8: hit and insert in one cycle while full
        step(1, k(106, 7), 1, k(109, 10), 10, 1, "R8");
        drain("R8");
        step(0, '0, 1, k(110, 11), 11, 1, "R8");
        step(0, '0, 1, k(111, 12), 12, 0, "R8");
        drain("R8");

        // R9/R10: flush with a search and insert injected while busy
        do_flush(1, k(109, 10), k(300, 1));
        drain("R10");
        step(1, k(109, 10), 0, '0, 0, 0, "R9");
        step(1, k(300, 1), 0, '0, 0, 0, "R10");
        step(1, k(110, 11), 0, '0, 0, 0, "R9");

        // R10: request in the cycle flush is raised is ignored
        step(0, '0, 1, k(400, 2), 20, 1, "R10");
        @(negedge clk);
        flush = 1'b1;
        lookup_valid = 1'b1; {lookup_tag, lookup_set} = k(400, 2);
        begin
            resp_t r;
            r.hit = 1'b0; r.data = '0; r.dirty = 1'b0; r.rq = "R10";
            exp_resp.push_back(r);
        end
        begin
            wb_t w;
            w.key = k(400, 2); w.data = pat(20); w.rq = "R9";
            exp_wb.push_back(w);
        end
        model.delete();
        m_flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        lookup_valid = 1'b0;
        while (flush_busy) @(negedge clk);
        m_flush = 1'b0;
        drain("R10");

        // refill after flush: four fills, fifth evicts the first
        for (int i = 0; i < N + 1; i++) begin
            step(0, '0, 1, k(500 + i, i), 30 + i, 1, "R5");
        end
        step(1, k(501, 1), 0, '0, 0, 0, "R5");
        drain("R5");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule